// File: doc/BRIEF.md
# DMA Host Write-Request Packet Generator

This block turns one local-to-host DMA job into a stream of write-request packets on a 32-bit packet link. A job is given as a 64-bit host start address (low and high halves), a byte count and a byte-lane swap mode, and is launched with a one-cycle start pulse. The block asks an arbiter for the link and waits for a grant. It then emits, for each request, one header word, one or two address words, and the payload words it pops from a show-ahead data FIFO.

A request never runs past a 4 GiB host address boundary, and it never carries more than a parameterised maximum payload. A job that would break either limit is cut into several requests that follow one another in address order. The header is chosen per request. A request whose upper address half is zero gets a short header followed by one address word. Any other request gets a long header followed by the high and then the low address word. A pulse on the done output marks the end of a job. A pulse on the error output marks a rejected or killed job.

Top module: `dma_wr_pkt_gen`

## Requirements
- R1: The job length in 32-bit words is the byte count divided by 4, rounded down. A job of fewer than 4 bytes raises `job_err` for one cycle in the cycle after the start pulse. It raises no `arb_req` and emits no word.
- R2: Before every header, `arb_req` is high and the block waits for `arb_gnt`. No header is sent without a grant, and no payload word is popped while `arb_req` is high.
- R3: No request carries more than MAX_WORDS (default 1024) payload words, and none runs past a multiple of 0x1_0000_0000 in host address. A job that crosses such a boundary ends one request at the last word below it, and the next request starts exactly at the boundary. Each request starts where the previous one ended.
- R4: A request whose address bits [63:32] are zero sends header 0x02FF_0000 with its length field ORed in, followed by one word holding address bits [31:0].
- R5: A request whose address bits [63:32] are non-zero sends header 0x03FF_0000 with its length field ORed in, followed by address bits [63:32] and then address bits [31:0].
- R6: The length field is header bits [9:0] and gives the payload word count modulo 1024, so a request of 1024 words carries 0.
- R7: Output byte lane i (bits [8i+7:8i]) of each payload word takes input lane (i XOR mode), where mode is the 2-bit swap value latched at the start pulse. So 0 means no change, 1 swaps the bytes within each 16-bit half, 2 swaps the halves, and 3 reverses all four bytes.
- R8: `pkt_valid` is high on every transmitted word. `pkt_frame` is high on every word of a request except its last payload word, and it is never high without `pkt_valid`.
- R9: While `pkt_valid` is high and `pkt_rdy` is low, the word, `pkt_valid` and `pkt_frame` stay unchanged in the next cycle.
- R10: `job_done` pulses for one cycle, in the cycle after the final payload word of the job is accepted.
- R11: When `job_abort` or `link_err` is seen while a job is active, `job_err` pulses in the next cycle, `pkt_valid` and `arb_req` drop, and the block returns to idle, where it accepts a new job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | One-cycle job launch, taken only when idle |
| job_addr_lo | input | 32 | Host start address bits [31:0], word aligned |
| job_addr_hi | input | 32 | Host start address bits [63:32] |
| job_bytes | input | CNT_W | Job length in bytes |
| job_swap | input | 2 | Byte-lane swap mode |
| job_abort | input | 1 | Kill the active job |
| link_err | input | 1 | Transmit error from the link, kills the active job |
| arb_req | output | 1 | Link request to the arbiter |
| arb_gnt | input | 1 | Link grant from the arbiter |
| fifo_data | input | 32 | Head word of the payload FIFO |
| fifo_avail | input | 1 | Payload FIFO holds a word |
| fifo_pop | output | 1 | Consume the FIFO head word at this clock edge |
| pkt_data | output | 32 | Packet word |
| pkt_valid | output | 1 | Packet word valid |
| pkt_frame | output | 1 | More words of this request follow |
| pkt_rdy | input | 1 | Link accepts the word at this clock edge |
| job_done | output | 1 | Job completed pulse |
| job_err | output | 1 | Job rejected or killed pulse |

## Verification
Every output word leaves a register loaded at the edge where the previous word is accepted, so the bench drives inputs on the falling edge and samples one time unit later. A word counts as accepted at the next rising edge only when `pkt_valid` and `pkt_rdy` are both high at that sample. `job_done` is due at the sample directly after the sample that recorded the final accepted word. `job_err` is due at the first sample after the cycle that carried a short start, an abort or a link error. The checks compare the sample cycle numbers against those offsets and do not simply wait for the pulse. The word-hold check compares each sample against the one before it whenever the earlier sample showed valid without ready.

// File: rtl/dma_wr_pkg.sv
package dma_wr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARB,
      ST_ADRH,
      ST_ADRL,
      ST_DATA,
      ST_DRAIN
   } pkt_state_e;

   localparam int          LEN_FIELD_W = 10;
   localparam logic [31:0] HDR_SHORT   = 32'h02FF_0000;
   localparam logic [31:0] HDR_LONG    = 32'h03FF_0000;

   function automatic logic [31:0] make_header(input logic wide,
                                               input logic [LEN_FIELD_W-1:0] len);
      return (wide ? HDR_LONG : HDR_SHORT) | {{(32-LEN_FIELD_W){1'b0}}, len};
   endfunction

endpackage

// File: rtl/dma_lane_swap.sv
module dma_lane_swap #(
   parameter int LANES = 4
) (
   input  logic [1:0]         mode,
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] LANE_ID = 2'(i);
      assign dout[8*i +: 8] = din[{LANE_ID ^ mode, 3'b000} +: 8];
   end

   // R7: a lane permutation moves bytes and never alters bit content
   always_comb begin
      p_swap_keeps_bits_r7 : assert ($countones(dout) == $countones(din));
   end

endmodule

// File: rtl/dma_req_planner.sv
module dma_req_planner #(
   parameter int MAX_WORDS = 1024,
   parameter int RW        = 30,
   parameter int LW        = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [63:0]   ld_addr,
   input  logic [RW-1:0] ld_words,
   input  logic          advance,
   output logic [63:0]   cur_addr,
   output logic [RW-1:0] rem_words,
   output logic [LW-1:0] req_len
);

   logic [63:0]   cur_q;
   logic [RW-1:0] rem_q;
   logic [30:0]   room;
   logic [63:0]   room_w;
   logic [63:0]   rem_w;
   logic [LW-1:0] len_cap;

   // words left before the next 4 GiB host boundary
   assign room   = 31'h4000_0000 - {1'b0, cur_q[31:2]};
   assign room_w = 64'(room);
   assign rem_w  = 64'(rem_q);

   always_comb begin
      len_cap = (rem_w < 64'(MAX_WORDS)) ? LW'(rem_q) : LW'(MAX_WORDS);
      req_len = (room_w < 64'(len_cap)) ? LW'(room) : len_cap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         rem_q <= '0;
      end else if (load) begin
         cur_q <= ld_addr;
         rem_q <= ld_words;
      end else if (advance) begin
         cur_q <= cur_q + 64'({req_len, 2'b00});
         rem_q <= rem_q - RW'(req_len);
      end
   end

   assign cur_addr  = cur_q;
   assign rem_words = rem_q;

   // R3: a planned request is non-empty, capped, and stays below the boundary
   p_req_window_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q != '0) |-> (req_len != '0 && 64'(req_len) <= 64'(MAX_WORDS) &&
                         ({1'b0, cur_q[31:0]} + 33'({req_len, 2'b00})) <= 33'h1_0000_0000));

   // R3: the next request begins where the previous one ended
   p_addr_follows_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> (cur_q == $past(cur_q) + 64'({$past(req_len), 2'b00})));

endmodule

// File: rtl/dma_wr_pkt_gen.sv
module dma_wr_pkt_gen
   import dma_wr_pkg::*;
#(
   parameter int MAX_WORDS = 1024,
   parameter int CNT_W     = 32,
   parameter bit SWAP_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             job_start,
   input  logic [31:0]      job_addr_lo,
   input  logic [31:0]      job_addr_hi,
   input  logic [CNT_W-1:0] job_bytes,
   input  logic [1:0]       job_swap,
   input  logic             job_abort,
   input  logic             link_err,
   output logic             arb_req,
   input  logic             arb_gnt,
   input  logic [31:0]      fifo_data,
   input  logic             fifo_avail,
   output logic             fifo_pop,
   output logic [31:0]      pkt_data,
   output logic             pkt_valid,
   output logic             pkt_frame,
   input  logic             pkt_rdy,
   output logic             job_done,
   output logic             job_err
);

   localparam int LW = $clog2(MAX_WORDS) + 1;
   localparam int RW = CNT_W - 2;

   if (MAX_WORDS < 1 || MAX_WORDS > 1024 || (MAX_WORDS & (MAX_WORDS - 1)) != 0) begin : g_bad_max
      $error("MAX_WORDS must be a power of two between 1 and 1024");
   end
   if (CNT_W < LW + 2 || CNT_W > 62) begin : g_bad_cnt
      $error("CNT_W out of range");
   end

   pkt_state_e    state_q;
   logic [1:0]    swap_q;
   logic [63:0]   req_addr_q;
   logic [LW-1:0] left_q;
   logic [31:0]   data_q;
   logic          valid_q;
   logic          frame_q;
   logic          done_q;
   logic          err_q;

   logic          load_ok;
   logic          kill;
   logic          too_short;
   logic          plan_load;
   logic          plan_adv;
   logic [63:0]   plan_addr;
   logic [RW-1:0] plan_rem;
   logic [LW-1:0] plan_len;
   logic [31:0]   swapped;
   logic          plan_wide;

   assign too_short = (job_bytes < CNT_W'(4));
   assign load_ok   = !valid_q || pkt_rdy;
   assign kill      = (state_q != ST_IDLE) && (job_abort || link_err);
   assign plan_load = (state_q == ST_IDLE) && job_start && !too_short;
   assign plan_adv  = (state_q == ST_ARB) && arb_gnt && load_ok && !kill;
   assign plan_wide = (plan_addr[63:32] != 32'd0);
   assign arb_req   = (state_q == ST_ARB);
   assign fifo_pop  = (state_q == ST_DATA) && load_ok && fifo_avail && !kill;

   dma_req_planner #(
      .MAX_WORDS (MAX_WORDS),
      .RW        (RW),
      .LW        (LW)
   ) u_plan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (plan_load),
      .ld_addr   ({job_addr_hi, job_addr_lo}),
      .ld_words  (job_bytes[CNT_W-1:2]),
      .advance   (plan_adv),
      .cur_addr  (plan_addr),
      .rem_words (plan_rem),
      .req_len   (plan_len)
   );

   if (SWAP_EN) begin : g_swap
      dma_lane_swap #(.LANES(4)) u_swap (
         .mode (swap_q),
         .din  (fifo_data),
         .dout (swapped)
      );
   end else begin : g_noswap
      assign swapped = fifo_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         swap_q     <= '0;
         req_addr_q <= '0;
         left_q     <= '0;
         data_q     <= '0;
         valid_q    <= 1'b0;
         frame_q    <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (kill) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
            frame_q <= 1'b0;
            err_q   <= 1'b1;
         end else begin
            unique case (state_q)
               ST_IDLE: begin
                  if (job_start) begin
                     if (too_short) begin
                        err_q <= 1'b1;
                     end else begin
                        swap_q  <= job_swap;
                        state_q <= ST_ARB;
                     end
                  end
               end
               ST_ARB: begin
                  if (load_ok) begin
                     if (arb_gnt) begin
                        data_q     <= make_header(plan_wide, LEN_FIELD_W'(plan_len));
                        valid_q    <= 1'b1;
                        frame_q    <= 1'b1;
                        req_addr_q <= plan_addr;
                        left_q     <= plan_len;
                        state_q    <= plan_wide ? ST_ADRH : ST_ADRL;
                     end else begin
                        valid_q <= 1'b0;
                        frame_q <= 1'b0;
                     end
                  end
               end
               ST_ADRH: begin
                  if (load_ok) begin
                     data_q  <= req_addr_q[63:32];
                     valid_q <= 1'b1;
                     frame_q <= 1'b1;
                     state_q <= ST_ADRL;
                  end
               end
               ST_ADRL: begin
                  if (load_ok) begin
                     data_q  <= req_addr_q[31:0];
                     valid_q <= 1'b1;
                     frame_q <= 1'b1;
                     state_q <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (load_ok) begin
                     if (fifo_avail) begin
                        data_q  <= swapped;
                        valid_q <= 1'b1;
                        frame_q <= (left_q != LW'(1));
                        left_q  <= left_q - LW'(1);
                        if (left_q == LW'(1)) begin
                           state_q <= (plan_rem == '0) ? ST_DRAIN : ST_ARB;
                        end
                     end else begin
                        valid_q <= 1'b0;
                        frame_q <= 1'b0;
                     end
                  end
               end
               ST_DRAIN: begin
                  if (pkt_rdy) begin
                     valid_q <= 1'b0;
                     frame_q <= 1'b0;
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign pkt_data  = data_q;
   assign pkt_valid = valid_q;
   assign pkt_frame = frame_q;
   assign job_done  = done_q;
   assign job_err   = err_q;

   // R9: a stalled word is held with its qualifiers
   p_hold_stalled_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !pkt_rdy && !job_abort && !link_err) |=>
         (pkt_valid && $stable(pkt_data) && $stable(pkt_frame)));

   // R8: frame only qualifies a valid word
   p_frame_needs_valid_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      pkt_frame |-> pkt_valid);

   // R2: no payload is consumed while the link is still being requested
   p_no_pop_in_request_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      arb_req |-> !fifo_pop);

   // R11: a kill while active yields an error and clears the link side
   p_kill_clears_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q != ST_IDLE) && (job_abort || link_err)) |=>
         (job_err && !pkt_valid && !arb_req));

   // R10: completion and error are never reported together
   p_done_err_excl_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(job_done && job_err));

   // R1: a short job never leaves idle
   p_short_job_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && job_start && too_short) |=> (job_err && !arb_req));

endmodule

// File: tb/sim_dma_wr_pkt_gen.sv
module sim_dma_wr_pkt_gen;

   localparam int MAXW = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        job_start = 1'b0;
   logic [31:0] job_addr_lo = '0;
   logic [31:0] job_addr_hi = '0;
   logic [31:0] job_bytes = '0;
   logic [1:0]  job_swap = '0;
   logic        job_abort = 1'b0;
   logic        link_err = 1'b0;
   logic        arb_req;
   logic        arb_gnt = 1'b0;
   logic [31:0] fifo_data;
   logic        fifo_avail = 1'b0;
   logic        fifo_pop;
   logic [31:0] pkt_data;
   logic        pkt_valid;
   logic        pkt_frame;
   logic        pkt_rdy = 1'b0;
   logic        job_done;
   logic        job_err;

   always #5 clk = ~clk;

   dma_wr_pkt_gen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .job_start  (job_start),
      .job_addr_lo(job_addr_lo),
      .job_addr_hi(job_addr_hi),
      .job_bytes  (job_bytes),
      .job_swap   (job_swap),
      .job_abort  (job_abort),
      .link_err   (link_err),
      .arb_req    (arb_req),
      .arb_gnt    (arb_gnt),
      .fifo_data  (fifo_data),
      .fifo_avail (fifo_avail),
      .fifo_pop   (fifo_pop),
      .pkt_data   (pkt_data),
      .pkt_valid  (pkt_valid),
      .pkt_frame  (pkt_frame),
      .pkt_rdy    (pkt_rdy),
      .job_done   (job_done),
      .job_err    (job_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int last_cap = -10;
   int src_idx = 0;
   bit pop_pend = 1'b0;
   int rdy_pct = 100;
   int avail_pct = 100;
   int gnt_pct = 100;
   bit gnt_seen = 1'b0;
   bit in_pkt = 1'b0;
   bit hold_prev = 1'b0;
   bit kill_flag = 1'b0;
   logic [31:0] hold_data;
   logic        hold_frame;
   logic [32:0] got_q[$];
   logic [32:0] exp_q[$];
   int          kind_q[$];

   function automatic logic [31:0] pay_word(input int k);
      return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   function automatic logic [31:0] lane_swap(input logic [1:0] m, input logic [31:0] w);
      logic [31:0] r;
      for (int i = 0; i < 4; i++) r[8*i +: 8] = w[8*(i ^ int'(m)) +: 8];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   assign fifo_data = pay_word(src_idx);

   // input driver and output monitor, both on the falling edge
   always @(negedge clk) begin
      if (pop_pend) src_idx++;
      pkt_rdy    = ($urandom_range(99) < rdy_pct);
      fifo_avail = ($urandom_range(99) < avail_pct);
      arb_gnt    = arb_req && ($urandom_range(99) < gnt_pct);
      #1;
      cyc++;
      if (hold_prev && !kill_flag)
         chk(pkt_valid && pkt_data == hold_data && pkt_frame == hold_frame,
             "R9 stalled word held", {31'd0, pkt_valid, pkt_data}, {32'd1, hold_data});
      hold_prev  = pkt_valid && !pkt_rdy;
      hold_data  = pkt_data;
      hold_frame = pkt_frame;
      if (pkt_valid && pkt_rdy && rst_n) begin
         if (!in_pkt)
            chk(gnt_seen, "R2 header only after grant", {63'd0, gnt_seen}, 64'd1);
         got_q.push_back({pkt_frame, pkt_data});
         last_cap = cyc;
         in_pkt   = pkt_frame;
         if (!pkt_frame) gnt_seen = 1'b0;
      end
      if (arb_req && arb_gnt) gnt_seen = 1'b1;
      pop_pend = fifo_pop;
   end

   task automatic build_exp(input logic [63:0] addr0, input logic [31:0] bytes,
                            input logic [1:0] mode);
      logic [63:0] addr;
      logic [63:0] rem;
      logic [63:0] room;
      logic [63:0] len;
      int k;
      exp_q.delete();
      kind_q.delete();
      addr = addr0;
      rem  = 64'(bytes >> 2);
      k    = src_idx;
      while (rem != 0) begin
         room = ((((addr >> 32) + 64'd1) << 32) - addr) >> 2;
         len  = rem;
         if (len > 64'(MAXW)) len = 64'(MAXW);
         if (len > room) len = room;
         if (addr[63:32] != 0) begin
            exp_q.push_back({1'b1, 32'h03FF_0000 | 32'(len % 1024)}); kind_q.push_back(0);
            exp_q.push_back({1'b1, addr[63:32]});                     kind_q.push_back(1);
         end else begin
            exp_q.push_back({1'b1, 32'h02FF_0000 | 32'(len % 1024)}); kind_q.push_back(0);
         end
         exp_q.push_back({1'b1, addr[31:0]}); kind_q.push_back(2);
         for (int j = 0; j < int'(len); j++) begin
            exp_q.push_back({(j != int'(len) - 1), lane_swap(mode, pay_word(k))});
            kind_q.push_back(3);
            k++;
         end
         addr = addr + (len << 2);
         rem  = rem - len;
      end
   endtask

   task automatic run_job(input logic [31:0] hi, input logic [31:0] lo,
                          input logic [31:0] bytes, input logic [1:0] mode);
      bit seen = 1'b0;
      build_exp({hi, lo}, bytes, mode);
      got_q.delete();
      @(negedge clk);
      job_addr_hi = hi;
      job_addr_lo = lo;
      job_bytes   = bytes;
      job_swap    = mode;
      job_start   = 1'b1;
      @(negedge clk);
      job_start   = 1'b0;
      job_swap    = 2'($urandom);
      job_addr_lo = $urandom;
      job_bytes   = $urandom;
      for (int t = 0; t < 60000; t++) begin
         #2;
         if (job_done || job_err) begin seen = 1'b1; break; end
         @(negedge clk);
      end
      if (exp_q.size() == 0) begin
         chk(seen && job_err && !job_done, "R1 short job rejected",
             {62'd0, job_done, job_err}, 64'd1);
         chk(got_q.size() == 0, "R1 short job emits nothing", 64'(got_q.size()), 64'd0);
      end else begin
         chk(seen && job_done && !job_err, "R10 job completes",
             {62'd0, job_done, job_err}, 64'd2);
         chk(cyc == last_cap + 1, "R10 done one cycle after last accept",
             64'(cyc), 64'(last_cap + 1));
         chk(got_q.size() == exp_q.size(), "R3 word count of job",
             64'(got_q.size()), 64'(exp_q.size()));
         for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
            string tag;
            case (kind_q[i])
               0:       tag = "R4/R5/R6 header word";
               1:       tag = "R5 high address word";
               2:       tag = "R3/R4 low address word";
               default: tag = "R7 payload word";
            endcase
            if (got_q[i][31:0] != exp_q[i][31:0])
               chk(1'b0, tag, 64'(got_q[i][31:0]), 64'(exp_q[i][31:0]));
            else if (got_q[i][32] != exp_q[i][32])
               chk(1'b0, "R8 frame flag", 64'(got_q[i][32]), 64'(exp_q[i][32]));
            else
               chk(1'b1, tag, 0, 0);
         end
      end
      @(negedge clk);
      #2;
      chk(!job_done && !job_err, "R10 single-cycle pulse", {62'd0, job_done, job_err}, 64'd0);
   endtask

   task automatic run_kill(input bit by_link);
      bit hit = 1'b0;
      build_exp(64'h0000_0000_0000_4000, 32'd4096, 2'd0);
      got_q.delete();
      @(negedge clk);
      job_addr_hi = 32'd0;
      job_addr_lo = 32'h4000;
      job_bytes   = 32'd4096;
      job_swap    = 2'd0;
      job_start   = 1'b1;
      @(negedge clk);
      job_start = 1'b0;
      for (int t = 0; t < 20000; t++) begin
         #2;
         if (by_link ? arb_req : (got_q.size() >= 20)) begin hit = 1'b1; break; end
         @(negedge clk);
      end
      chk(hit, "R11 reached kill point", {63'd0, hit}, 64'd1);
      kill_flag = 1'b1;
      if (by_link) link_err = 1'b1; else job_abort = 1'b1;
      pop_pend = 1'b0;
      @(negedge clk);
      link_err  = 1'b0;
      job_abort = 1'b0;
      #2;
      chk(job_err, "R11 error pulse after kill", {63'd0, job_err}, 64'd1);
      chk(!pkt_valid, "R11 valid dropped", {63'd0, pkt_valid}, 64'd0);
      chk(!arb_req, "R11 request dropped", {63'd0, arb_req}, 64'd0);
      @(negedge clk);
      #2;
      chk(!job_err && !pkt_valid && !arb_req, "R11 stays idle",
          {61'd0, job_err, pkt_valid, arb_req}, 64'd0);
      in_pkt    = 1'b0;
      gnt_seen  = 1'b0;
      kill_flag = 1'b0;
   endtask

   initial begin
      #1_900_000;
      chk(1'b0, "watchdog expired", 64'(cyc), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20417));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #2;
      chk(!pkt_valid && !pkt_frame && !arb_req && !fifo_pop && !job_done && !job_err,
          "reset state quiet",
          {58'd0, pkt_valid, pkt_frame, arb_req, fifo_pop, job_done, job_err}, 64'd0);

      // R1: short and odd byte counts
      run_job(32'd0, 32'h0000_1000, 32'd2, 2'd0);
      run_job(32'd0, 32'h0000_1000, 32'd0, 2'd1);
      run_job(32'd0, 32'h0000_1000, 32'd6, 2'd0);
      // R3/R4/R5: boundary crossing with a full-size first request
      run_job(32'd0, 32'hFFFF_F000, 32'd8192, 2'd0);
      // R3/R6: split by the size cap only
      run_job(32'd0, 32'h0000_0000, 32'd5000, 2'd0);
      // R3: short request just below the boundary
      run_job(32'd0, 32'hFFFF_FFF8, 32'd64, 2'd2);
      // R5/R7: long header with every swap mode
      for (int m = 0; m < 4; m++) run_job(32'd2, 32'h8000_0010, 32'd40, 2'(m));
      // R9: heavy backpressure and FIFO bubbles
      rdy_pct = 30; avail_pct = 50; gnt_pct = 20;
      run_job(32'd7, 32'hFFFF_FF00, 32'd1024, 2'd3);
      // R11: kill paths, then recovery
      rdy_pct = 80; avail_pct = 90; gnt_pct = 60;
      run_kill(1'b0);
      run_job(32'd0, 32'h0000_2000, 32'd128, 2'd1);
      run_kill(1'b1);
      run_job(32'd1, 32'h0000_0000, 32'd256, 2'd2);

      // constrained random jobs
      for (int j = 0; j < 12; j++) begin
         int sel;
         logic [31:0] hi, lo, by;
         sel = $urandom_range(3);
         hi  = (sel == 0 || sel == 1) ? 32'd0 : (sel == 2) ? 32'd1 : $urandom_range(2, 32'hFFFF);
         lo  = (sel == 1) ? 32'hFFFF_F000 + ($urandom_range(1023) << 2) : ($urandom & ~32'd3);
         by  = $urandom_range(1, 8192);
         rdy_pct   = $urandom_range(40, 100);
         avail_pct = $urandom_range(40, 100);
         gnt_pct   = $urandom_range(20, 100);
         run_job(hi, lo, by, 2'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule